// File: doc/BRIEF.md
# PHY Management Control Register

This block is the basic control register of an Ethernet PHY, reached over a plain management port. The port has an address, write data, a write strobe and combinational read data. Management software uses it to set loopback, forced speed, auto-negotiation enable, isolation and duplex. It can also kick off a new negotiation or trigger a timed soft reset of the PHY core. The register turns these settings into level and pulse outputs that feed the PHY core directly.

A write that sets the reset bit raises a reset output for a fixed number of clock cycles. The length is set by the `RST_CYCLES` parameter, for example 50 cycles at 50 MHz for about 1 µs. During that interval the register ignores every write, and its writable fields hold their power-on values. When the interval ends, the reset bit drops back to 0 by itself. The reported speed is the forced speed bit only while auto-negotiation is off. Otherwise the speed follows the negotiated-speed input.

Top module: `phy_mgmt_ctrl`

## Requirements
- R1: After `rst_ni` is asserted, a read of the control address returns 16'h3000. The outputs are then phy_rst_o=0, loopback_o=0, an_en_o=1, isolate_o=0, duplex_full_o=0 and restart_an_o=0.
- R2: An accepted write to the control address with bit 15 set raises `phy_rst_o` in the next cycle. It stays high for exactly `RST_CYCLES` cycles and then clears without another write. Bit 15 reads as `phy_rst_o`.
- R3: A soft reset returns all writable fields to their defaults (bit 13=1, bit 12=1, bits 14, 10, 8 = 0). The other bits of the write that started it are discarded.
- R4: While `phy_rst_o` is high, every write is ignored, including one with bit 15 set. The read data and outputs keep their values.
- R5: A write with bit 15 clear never starts a soft reset.
- R6: Bit 14 is the loopback control and drives `loopback_o`. It is cleared by writing 0, by a soft reset or by `rst_ni`.
- R7: Bit 13 reads back exactly what was written. `speed_100_o` equals bit 13 when auto-negotiation is disabled, and equals `an_speed_100_i` when it is enabled (1 means 100 Mb/s, 0 means 10 Mb/s).
- R8: Bit 12 drives `an_en_o`, bit 10 drives `isolate_o` and bit 8 drives `duplex_full_o` (1 means full duplex). Each reads back what was written.
- R9: Take an accepted write with bit 15 clear, bit 9 set and bit 12 set. It gives a single-cycle `restart_an_o` pulse in the next cycle, and bit 9 reads 1 only in that cycle. If bit 12 of the write is 0, there is no pulse and bit 9 reads 0.
- R10: Bit 11 and bits 7:0 always read 0, whatever was written to them.
- R11: A write to any address other than `CTRL_ADDR` has no effect, and a read of such an address returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mgmt_addr_i | input | ADDR_W | Register address |
| mgmt_wdata_i | input | 16 | Write data |
| mgmt_we_i | input | 1 | Write strobe, one write per cycle |
| mgmt_rdata_o | output | 16 | Read data for `mgmt_addr_i` (combinational) |
| an_speed_100_i | input | 1 | Negotiated speed from the negotiation logic, 1 = 100 Mb/s |
| phy_rst_o | output | 1 | Soft-reset level to the PHY core |
| loopback_o | output | 1 | Loopback level |
| speed_100_o | output | 1 | Effective speed, 1 = 100 Mb/s |
| an_en_o | output | 1 | Auto-negotiation enable level |
| isolate_o | output | 1 | Isolate MAC-side interface |
| duplex_full_o | output | 1 | Full-duplex select |
| restart_an_o | output | 1 | One-cycle negotiation restart pulse |

## Verification
A field register holding a wrong value shows up in the same cycle on its level output and on the read data, so any compare made while the register is addressed catches it. A reset counter that is off by one shows only at the falling edge of `phy_rst_o`. That edge arrives one cycle early or late, and the counted pulse width reveals the error after `RST_CYCLES` cycles. A write gate that leaks during the reset interval changes a level output in the cycle after the ignored write. A speed select that is wrong only shows when the negotiated-speed input differs from the forced bit, so that input is toggled against the bit.

// File: rtl/phy_mgmt_pkg.sv
package phy_mgmt_pkg;
  localparam int BIT_SRST  = 15;
  localparam int BIT_LOOP  = 14;
  localparam int BIT_SPD   = 13;
  localparam int BIT_ANEN  = 12;
  localparam int BIT_PWDN  = 11;
  localparam int BIT_ISO   = 10;
  localparam int BIT_RSTAN = 9;
  localparam int BIT_DUP   = 8;

  typedef struct packed {
    logic loopback;
    logic speed_100;
    logic an_en;
    logic isolate;
    logic duplex_full;
  } ctrl_fields_t;

  localparam ctrl_fields_t CTRL_DEFAULT = '{
    loopback:    1'b0,
    speed_100:   1'b1,
    an_en:       1'b1,
    isolate:     1'b0,
    duplex_full: 1'b0
  };
endpackage

// File: rtl/soft_rst_timer.sv
module soft_rst_timer #(
  parameter int RST_CYCLES = 50
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o
);
  localparam int CNT_W = $clog2(RST_CYCLES + 1);
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(RST_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (busy_q) begin
      if (cnt_q == '0) busy_q <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
    end else if (start_i) begin
      busy_q <= 1'b1;
      cnt_q  <= LOAD;
    end
  end

  assign busy_o = busy_q;
endmodule

// File: rtl/ctrl_field_regs.sv
module ctrl_field_regs
  import phy_mgmt_pkg::*;
(
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_en_i,
  input  logic [15:0]  wdata_i,
  output ctrl_fields_t fields_o,
  output logic         restart_o
);
  ctrl_fields_t fields_q, wr_fields;
  logic         restart_q;
  logic         unused_wbits;

  assign unused_wbits = ^{wdata_i[BIT_PWDN], wdata_i[7:0]};

  always_comb begin
    wr_fields.loopback    = wdata_i[BIT_LOOP];
    wr_fields.speed_100   = wdata_i[BIT_SPD];
    wr_fields.an_en       = wdata_i[BIT_ANEN];
    wr_fields.isolate     = wdata_i[BIT_ISO];
    wr_fields.duplex_full = wdata_i[BIT_DUP];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fields_q  <= CTRL_DEFAULT;
      restart_q <= 1'b0;
    end else begin
      restart_q <= wr_en_i & ~wdata_i[BIT_SRST] & wdata_i[BIT_RSTAN] & wdata_i[BIT_ANEN];
      if (wr_en_i) fields_q <= wdata_i[BIT_SRST] ? CTRL_DEFAULT : wr_fields;
    end
  end

  assign fields_o  = fields_q;
  assign restart_o = restart_q;
endmodule

// File: rtl/ctrl_readback.sv
module ctrl_readback
  import phy_mgmt_pkg::*;
(
  input  logic         addr_hit_i,
  input  logic         busy_i,
  input  ctrl_fields_t fields_i,
  input  logic         restart_i,
  input  logic         an_speed_100_i,
  output logic [15:0]  rdata_o,
  output logic         speed_100_o
);
  logic [15:0] word;

  always_comb begin
    word            = '0;
    word[BIT_SRST]  = busy_i;
    word[BIT_LOOP]  = fields_i.loopback;
    word[BIT_SPD]   = fields_i.speed_100;
    word[BIT_ANEN]  = fields_i.an_en;
    word[BIT_ISO]   = fields_i.isolate;
    word[BIT_RSTAN] = restart_i;
    word[BIT_DUP]   = fields_i.duplex_full;
  end

  assign rdata_o     = addr_hit_i ? word : '0;
  assign speed_100_o = fields_i.an_en ? an_speed_100_i : fields_i.speed_100;
endmodule

// File: rtl/phy_mgmt_ctrl.sv
module phy_mgmt_ctrl
  import phy_mgmt_pkg::*;
#(
  parameter int ADDR_W     = 5,
  parameter int CTRL_ADDR  = 0,
  parameter int RST_CYCLES = 50
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] mgmt_addr_i,
  input  logic [15:0]       mgmt_wdata_i,
  input  logic              mgmt_we_i,
  output logic [15:0]       mgmt_rdata_o,
  input  logic              an_speed_100_i,
  output logic              phy_rst_o,
  output logic              loopback_o,
  output logic              speed_100_o,
  output logic              an_en_o,
  output logic              isolate_o,
  output logic              duplex_full_o,
  output logic              restart_an_o
);
  localparam logic [ADDR_W-1:0] HIT_ADDR = ADDR_W'(CTRL_ADDR);

  logic         addr_hit, busy, wr_acc, restart;
  ctrl_fields_t fields;

  assign addr_hit = (mgmt_addr_i == HIT_ADDR);
  assign wr_acc   = mgmt_we_i & addr_hit & ~busy;

  soft_rst_timer #(.RST_CYCLES(RST_CYCLES)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (wr_acc & mgmt_wdata_i[BIT_SRST]),
    .busy_o  (busy)
  );

  ctrl_field_regs u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_acc),
    .wdata_i   (mgmt_wdata_i),
    .fields_o  (fields),
    .restart_o (restart)
  );

  ctrl_readback u_rb (
    .addr_hit_i     (addr_hit),
    .busy_i         (busy),
    .fields_i       (fields),
    .restart_i      (restart),
    .an_speed_100_i (an_speed_100_i),
    .rdata_o        (mgmt_rdata_o),
    .speed_100_o    (speed_100_o)
  );

  assign phy_rst_o     = busy;
  assign loopback_o    = fields.loopback;
  assign an_en_o       = fields.an_en;
  assign isolate_o     = fields.isolate;
  assign duplex_full_o = fields.duplex_full;
  assign restart_an_o  = restart;
endmodule

// File: rtl/phy_mgmt_ctrl_chk.sv
module phy_mgmt_ctrl_chk #(
  parameter int ADDR_W     = 5,
  parameter int CTRL_ADDR  = 0,
  parameter int RST_CYCLES = 50
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] mgmt_addr_i,
  input logic [15:0]       mgmt_wdata_i,
  input logic              mgmt_we_i,
  input logic [15:0]       mgmt_rdata_o,
  input logic              an_speed_100_i,
  input logic              phy_rst_o,
  input logic              loopback_o,
  input logic              speed_100_o,
  input logic              an_en_o,
  input logic              isolate_o,
  input logic              duplex_full_o,
  input logic              restart_an_o
);
  localparam logic [ADDR_W-1:0] HIT_ADDR = ADDR_W'(CTRL_ADDR);

  logic hit;
  int   run_cnt;

  assign hit = (mgmt_addr_i == HIT_ADDR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        run_cnt <= 0;
    else if (phy_rst_o) run_cnt <= run_cnt + 1;
    else                run_cnt <= 0;
  end

  AST_RST_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mgmt_we_i && hit && mgmt_wdata_i[15] && !phy_rst_o) |=> phy_rst_o); // R2
  AST_RST_LENGTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(phy_rst_o) |-> (run_cnt == RST_CYCLES)); // R2
  AST_RST_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit |-> (mgmt_rdata_o[15] == phy_rst_o)); // R2
  AST_RST_DEFAULTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phy_rst_o |-> (!loopback_o && an_en_o && !isolate_o && !duplex_full_o && !restart_an_o)); // R3
  AST_BUSY_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phy_rst_o |=> ($stable(loopback_o) && $stable(an_en_o) && $stable(isolate_o) && $stable(duplex_full_o))); // R4
  AST_NO_RST_ON_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mgmt_we_i && !mgmt_wdata_i[15] && !phy_rst_o) |=> !phy_rst_o); // R5
  AST_SPEED_NEG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    an_en_o |-> (speed_100_o == an_speed_100_i)); // R7
  AST_SPEED_FORCED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!an_en_o && hit) |-> (speed_100_o == mgmt_rdata_o[13])); // R7
  AST_RESTART_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_an_o |=> !restart_an_o); // R9
  AST_RESTART_NEEDS_AN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_an_o |-> an_en_o); // R9
  AST_RSVD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit |-> (!mgmt_rdata_o[11] && mgmt_rdata_o[7:0] == 8'h00)); // R10
  AST_MISS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit |-> (mgmt_rdata_o == 16'h0000)); // R11
endmodule

bind phy_mgmt_ctrl phy_mgmt_ctrl_chk #(
  .ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR), .RST_CYCLES(RST_CYCLES)
) u_chk (.*);

// File: tb/phy_mgmt_ctrl_tb_top.sv
`timescale 1ns/1ps
module phy_mgmt_ctrl_tb_top;
  localparam int ADDR_W = 5;
  localparam int RST_CYCLES = 50;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [15:0]       wdata = '0;
  logic              we = 1'b0;
  logic              an_spd = 1'b0;
  logic [15:0]       rdata;
  logic phy_rst, lb, spd, an_en, iso, dup, rs_an;

  int vectors = 0;
  int errors  = 0;
  bit done    = 0;

  // behavioural reference state
  int m_left;
  bit m_lb, m_spd, m_an, m_iso, m_dup, m_rs;

  always #5 clk = ~clk;

  phy_mgmt_ctrl #(.ADDR_W(ADDR_W), .CTRL_ADDR(0), .RST_CYCLES(RST_CYCLES)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .mgmt_addr_i(addr), .mgmt_wdata_i(wdata),
    .mgmt_we_i(we), .mgmt_rdata_o(rdata), .an_speed_100_i(an_spd),
    .phy_rst_o(phy_rst), .loopback_o(lb), .speed_100_o(spd), .an_en_o(an_en),
    .isolate_o(iso), .duplex_full_o(dup), .restart_an_o(rs_an)
  );

  task automatic model_defaults();
    m_left = 0; m_lb = 0; m_spd = 1; m_an = 1; m_iso = 0; m_dup = 0; m_rs = 0;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) model_defaults();
    else begin
      bit rs_next;
      rs_next = 0;
      if (m_left > 0) m_left--;
      else if (we && addr == 0) begin
        if (wdata[15]) begin
          model_defaults();
          m_left = RST_CYCLES;
        end else begin
          m_lb = wdata[14]; m_spd = wdata[13]; m_an = wdata[12];
          m_iso = wdata[10]; m_dup = wdata[8];
          rs_next = wdata[9] && wdata[12];
        end
      end
      m_rs = rs_next;
    end
  end

  task automatic cmp(string req, string what, int act, int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic [15:0] exp_rd;
      exp_rd = 16'h0;
      if (addr == 0) exp_rd = {(m_left > 0), m_lb, m_spd, m_an, 1'b0, m_iso, m_rs, m_dup, 8'h00};
      cmp("R2/R1", "phy_rst_o", phy_rst, (m_left > 0));
      cmp("R6", "loopback_o", lb, m_lb);
      cmp("R7", "speed_100_o", spd, m_an ? an_spd : m_spd);
      cmp("R8", "an_en_o", an_en, m_an);
      cmp("R8", "isolate_o", iso, m_iso);
      cmp("R8", "duplex_full_o", dup, m_dup);
      cmp("R9", "restart_an_o", rs_an, m_rs);
      cmp(addr == 0 ? "R10/R3/R4" : "R11", "mgmt_rdata_o", rdata, exp_rd);
    end
  end

  task automatic drive(input logic [ADDR_W-1:0] a, input logic w, input logic [15:0] d);
    @(posedge clk); #2;
    addr = a; we = w; wdata = d;
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [15:0] d);
    drive(a, 1'b1, d);
    drive(a, 1'b0, 16'h0);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive(addr, 1'b0, 16'h0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    idle(3);                               // R1 defaults
    wr(0, 16'h4000); idle(1);              // R6 loopback on, an off
    wr(0, 16'h0000); an_spd = 1'b1; idle(2); // R6 clear, R7 forced 10M vs negotiated
    wr(0, 16'h2500); idle(1);              // R7 R8 forced 100M, isolate, full duplex
    wr(0, 16'h3000); an_spd = 1'b0; idle(1); an_spd = 1'b1; idle(1); // R7 follows negotiated
    wr(0, 16'h3200); idle(2);              // R9 restart pulse
    wr(0, 16'h0200); idle(2);              // R9 no pulse without an enable
    wr(0, 16'h0BFF); idle(1);              // R10 reserved bits read 0
    wr(7, 16'hFFFF); idle(1);              // R11 other address ignored
    drive(5, 1'b0, 16'h0); idle(1);        // R11 read miss
    wr(0, 16'h7F00); idle(1);              // R5 bit15 clear
    wr(0, 16'hC500);                       // R2 R3 soft reset
    wr(0, 16'h4500);                       // R4 ignored
    wr(0, 16'h8000);                       // R4 ignored restart of reset
    idle(RST_CYCLES + 3);
    wr(0, 16'h4100); idle(1);
    wr(0, 16'h8000); idle(10);
    #1 rst_n = 1'b0; idle(2); #1 rst_n = 1'b1; idle(3); // R6 R1 async reset mid-interval
    for (int i = 0; i < 40; i++) begin
      an_spd = i[1];
      wr((i % 3 == 0) ? 5'd0 : 5'(i), 16'(i * 16'h1357) & 16'h7FFF);
    end
    wr(0, 16'hFFFF); idle(RST_CYCLES + 4); // R2 R3 full-pattern reset
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule